// File: doc/BRIEF.md
# Feedback-Divider Ramp Sequencer

This block moves the feedback divider of a running PLL to a new value without losing lock, by handing the change to an external hardware ramp generator. A client requests a new divider value. If it matches the current one, the block finishes at once and touches nothing. Otherwise it runs a fixed sequence:
- drive the two ramp step sizes and enter slowdown mode;
- wait a settle delay, then write the new divider;
- wait a second settle delay, then enable the dynamic ramp;
- sample a synchronized ramp-done flag once per microsecond.

Sampling ends when the flag is seen or when the poll budget runs out. In both cases the block drops slowdown mode and the ramp enable. It then pulses `done` and reports `error` if the ramp never finished.

A prescaler derives the microsecond tick from the clock frequency parameter. The analog PLL and the ramp generator sit outside the block. The block's side of that link is a set of plain level signals.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: After reset, busy, done, error, slowdown and ramp enable are low, both step outputs are 0 and the divider output equals RESET_NDIV.
- R2: A request is taken only when req is high while busy and done are both low; a request raised while busy is ignored and does not change the divider written by the sequence in progress.
- R3: A request whose value equals the current divider pulses done in the cycle after it is taken, with busy, slowdown and error low and the divider unchanged.
- R4: On taking a differing request, slowdown rises together with step A = 8'h2B and step B = 8'h0B.
- R5: The divider output changes exactly SETTLE_US microseconds (CLK_MHZ*SETTLE_US cycles) after slowdown rises, and slowdown is high when it changes.
- R6: The ramp enable rises exactly SETTLE_US microseconds after the divider changes.
- R7: The ramp-done input passes through a two-flop synchronizer and is sampled once per microsecond after ramp enable. The sequence ends at the first sample that sees it high, so done follows ramp enable by a whole number of microseconds.
- R8: If POLL_LIMIT samples all see ramp-done low, the sequence ends with error = 1 exactly POLL_LIMIT microseconds after ramp enable rose.
- R9: In the cycle done is high after a ramp, slowdown and ramp enable are both low, on success and on timeout.
- R10: done is high for exactly one cycle. busy is high from the cycle after a differing request is taken until done. error holds its value until the next request is taken, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request for a new divider value |
| req_ndiv | input | NDIV_W | Requested divider value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last sequence timed out |
| pll_ndiv | output | NDIV_W | Feedback divider driven to the PLL |
| pll_step_a | output | STEP_W | Ramp step size A |
| pll_step_b | output | STEP_W | Ramp step size B |
| pll_slowdown | output | 1 | Slowdown-using-PLL mode |
| pll_ramp_en | output | 1 | Dynamic ramp enable |
| pll_ramp_done | input | 1 | Ramp finished flag, asynchronous |

## Verification
A wrong microsecond count or settle count shows at the ports as an edge that lands at the wrong time. The divider write or the ramp enable would appear one or more cycles off the exact CLK_MHZ*SETTLE_US spacing within the first few microseconds of a request. A wrong poll count or a lost synchronized flag shows up later. done would land off the microsecond grid after ramp enable, or a timeout would fire before or after POLL_LIMIT microseconds. A state machine that fails to leave slowdown mode is visible in the very cycle done pulses.

// File: rtl/ndiv_ramp_pkg.sv
package ndiv_ramp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE_PRE,
    ST_SETTLE_POST,
    ST_POLL
  } ramp_state_e;

  localparam logic [7:0] STEP_A_CODE = 8'h2B;
  localparam logic [7:0] STEP_B_CODE = 8'h0B;

  // Bits needed to count 0 .. limit-1
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // True on the final count of a window of 'limit' events
  function automatic logic window_end(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ndiv_ramp_tick.sv
module ndiv_ramp_tick #(
  parameter int unsigned CYC_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = ndiv_ramp_pkg::cnt_width(CYC_PER_US);
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!run || cnt_q == LAST) cnt_q <= '0;
    else                           cnt_q <= cnt_q + CW'(1);
  end

  assign tick = run && (cnt_q == LAST);

  assert_tick_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_tick_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/ndiv_ramp_sync.sv
module ndiv_ramp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_async};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ndiv_ramp_evtcnt.sv
module ndiv_ramp_evtcnt #(
  parameter int unsigned LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic [ndiv_ramp_pkg::cnt_width(LIMIT)-1:0] cnt
);
  localparam int unsigned EW = ndiv_ramp_pkg::cnt_width(LIMIT);
  localparam logic [EW-1:0] LAST = EW'(LIMIT - 1);

  logic [EW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= cnt_q + EW'(1);
  end

  assign cnt = cnt_q;

  assert_evt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/ndiv_ramp_ctrl.sv
module ndiv_ramp_ctrl #(
  parameter int unsigned NDIV_W      = 8,
  parameter int unsigned STEP_W      = 8,
  parameter int unsigned CLK_MHZ     = 200,
  parameter int unsigned SETTLE_US   = 1,
  parameter int unsigned POLL_LIMIT  = 500,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NDIV_W-1:0] RESET_NDIV = NDIV_W'(40)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [NDIV_W-1:0] req_ndiv,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [NDIV_W-1:0] pll_ndiv,
  output logic [STEP_W-1:0] pll_step_a,
  output logic [STEP_W-1:0] pll_step_b,
  output logic              pll_slowdown,
  output logic              pll_ramp_en,
  input  logic              pll_ramp_done
);
  import ndiv_ramp_pkg::*;

  localparam int unsigned EVT_LIMIT = max_u(POLL_LIMIT, SETTLE_US);
  localparam int unsigned EW        = cnt_width(EVT_LIMIT);

  ramp_state_e state_q, state_d;
  logic [NDIV_W-1:0] ndiv_q, target_q;
  logic [STEP_W-1:0] step_a_q, step_b_q;
  logic slow_q, ramp_q, done_q, err_q;

  // Named internal events
  logic          run, tick, done_sync;
  logic          accept, same_n, start_ramp;
  logic          settle_end, poll_ok, poll_expire, finish;
  logic          evt_clr, evt_inc;
  logic [EW-1:0] evt;

  ndiv_ramp_tick #(.CYC_PER_US(CLK_MHZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  ndiv_ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pll_ramp_done), .q(done_sync)
  );

  ndiv_ramp_evtcnt #(.LIMIT(EVT_LIMIT)) u_evt (
    .clk(clk), .rst_n(rst_n), .clr(evt_clr), .inc(evt_inc), .cnt(evt)
  );

  assign run         = (state_q != ST_IDLE);
  assign accept      = req && (state_q == ST_IDLE) && !done_q;
  assign same_n      = (req_ndiv == ndiv_q);
  assign start_ramp  = accept && !same_n;
  assign settle_end  = tick && window_end(int'(evt), SETTLE_US);
  assign poll_ok     = tick && done_sync;
  assign poll_expire = tick && !done_sync && window_end(int'(evt), POLL_LIMIT);
  assign finish      = (state_q == ST_POLL) && (poll_ok || poll_expire);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:        if (start_ramp) state_d = ST_SETTLE_PRE;
      ST_SETTLE_PRE:  if (settle_end) state_d = ST_SETTLE_POST;
      ST_SETTLE_POST: if (settle_end) state_d = ST_POLL;
      ST_POLL:        if (finish)     state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  assign evt_clr = (state_d != state_q);
  assign evt_inc = tick && !evt_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ndiv_q   <= RESET_NDIV;
      target_q <= '0;
      step_a_q <= '0;
      step_b_q <= '0;
      slow_q   <= 1'b0;
      ramp_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (accept && same_n) || finish;
      if (accept) err_q <= 1'b0;
      else if (finish) err_q <= poll_expire;
      if (start_ramp) begin
        target_q <= req_ndiv;
        step_a_q <= STEP_W'(STEP_A_CODE);
        step_b_q <= STEP_W'(STEP_B_CODE);
        slow_q   <= 1'b1;
      end
      if (state_q == ST_SETTLE_PRE && settle_end)  ndiv_q <= target_q;
      if (state_q == ST_SETTLE_POST && settle_end) ramp_q <= 1'b1;
      if (finish) begin
        slow_q <= 1'b0;
        ramp_q <= 1'b0;
      end
    end
  end

  assign busy         = run;
  assign done         = done_q;
  assign error        = err_q;
  assign pll_ndiv     = ndiv_q;
  assign pll_step_a   = step_a_q;
  assign pll_step_b   = step_b_q;
  assign pll_slowdown = slow_q;
  assign pll_ramp_en  = ramp_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_same_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && same_n) |=> (done_q && !slow_q && !run));
  assert_write_in_slowdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ndiv_q) |-> (slow_q && $past(slow_q)));
  assert_ramp_needs_slowdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_q |-> slow_q);
  assert_exit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!slow_q && !ramp_q));
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> done_q);
  assert_busy_ignores_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state_q != ST_POLL) |=> $stable(target_q));
endmodule

// File: tb/ndiv_ramp_ctrl_tb.sv
module ndiv_ramp_ctrl_tb;
  localparam int unsigned NW = 8;
  localparam int unsigned CMHZ = 4;
  localparam int unsigned SETTLE = 1;
  localparam int unsigned PLIM = 500;
  localparam logic [NW-1:0] RST_N_VAL = 8'd40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [NW-1:0] req_ndiv = '0;
  logic busy, done, error, slowdown, ramp_en, ramp_done_raw;
  logic [NW-1:0] ndiv;
  logic [7:0] step_a, step_b;

  always #2.5 clk = ~clk;

  ndiv_ramp_ctrl #(.NDIV_W(NW), .STEP_W(8), .CLK_MHZ(CMHZ), .SETTLE_US(SETTLE),
                   .POLL_LIMIT(PLIM), .SYNC_STAGES(2), .RESET_NDIV(RST_N_VAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ndiv(req_ndiv),
    .busy(busy), .done(done), .error(error), .pll_ndiv(ndiv),
    .pll_step_a(step_a), .pll_step_b(step_b), .pll_slowdown(slowdown),
    .pll_ramp_en(ramp_en), .pll_ramp_done(ramp_done_raw)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Ramp generator model
  int ramp_delay = 0;
  bit ramp_never = 0;
  int rcnt = 0;
  always @(posedge clk) begin
    if (!ramp_en) begin
      rcnt <= 0;
      ramp_done_raw <= 1'b0;
    end else if (!ramp_never && rcnt >= ramp_delay) begin
      ramp_done_raw <= 1'b1;
    end else begin
      rcnt <= rcnt + 1;
    end
  end

  // Monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic prev_slow = 0, prev_ramp = 0, prev_done = 0;
  logic [NW-1:0] prev_ndiv = RST_N_VAL;
  int tS = 0, tN = 0, tR = 0, tD = 0, done_cnt = 0;
  logic d_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_slow && slowdown) begin
        tS = cyc;
        chk(step_a == 8'h2B, "R4 step A", step_a, 8'h2B);
        chk(step_b == 8'h0B, "R4 step B", step_b, 8'h0B);
      end
      if (ndiv != prev_ndiv) begin
        tN = cyc;
        chk(slowdown, "R5 slowdown at write", slowdown, 1);
      end
      if (!prev_ramp && ramp_en) tR = cyc;
      if (done) begin
        tD = cyc;
        d_err = error;
        done_cnt++;
        chk(!slowdown && !ramp_en, "R9 exit clears", {slowdown, ramp_en}, 0);
      end
      if (prev_done) chk(!done, "R10 done pulse width", done, 0);
      prev_slow = slowdown;
      prev_ramp = ramp_en;
      prev_done = done;
      prev_ndiv = ndiv;
    end
  end

  task automatic same_req();
    logic [NW-1:0] cur;
    cur = ndiv;
    @(negedge clk); req = 1'b1; req_ndiv = cur;
    @(negedge clk); req = 1'b0;
    chk(done == 1'b1, "R3 same value done", done, 1);
    chk(!busy, "R3 same value busy", busy, 0);
    chk(!slowdown, "R3 same value slowdown", slowdown, 0);
    chk(!error, "R3 same value error / R10 clear", error, 0);
    chk(ndiv == cur, "R3 divider unchanged", ndiv, cur);
  endtask

  task automatic run_ramp(input logic [NW-1:0] tgt, input int dly, input bit never, input bit poke);
    int start_cnt;
    int span;
    ramp_delay = dly;
    ramp_never = never;
    start_cnt = done_cnt;
    @(negedge clk); req = 1'b1; req_ndiv = tgt;
    @(negedge clk); req = 1'b0;
    chk(busy, "R10 busy after accept", busy, 1);
    chk(!error, "R10 error cleared on accept", error, 0);
    if (poke) begin
      @(negedge clk); req = 1'b1; req_ndiv = ~tgt;
      @(negedge clk); req = 1'b0;
    end
    while (done_cnt == start_cnt && !finished) @(negedge clk);
    chk(!busy, "R10 busy low at done", busy, 0);
    chk(tN - tS == int'(CMHZ * SETTLE), "R5 write delay", tN - tS, CMHZ * SETTLE);
    chk(tR - tN == int'(CMHZ * SETTLE), "R6 enable delay", tR - tN, CMHZ * SETTLE);
    chk(ndiv == tgt, poke ? "R2 busy request ignored" : "R5 divider value", ndiv, tgt);
    span = tD - tR;
    if (never) begin
      chk(d_err == 1'b1, "R8 timeout error", d_err, 1);
      chk(span == int'(PLIM * CMHZ), "R8 timeout time", span, PLIM * CMHZ);
    end else begin
      chk(d_err == 1'b0, "R7 success error", d_err, 0);
      chk(span % int'(CMHZ) == 0, "R7 poll grid", span % int'(CMHZ), 0);
      chk(span >= dly && span <= dly + int'(CMHZ) + 4, "R7 poll latency", span, dly);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error, "R1 reset status", {busy, done, error}, 0);
    chk(!slowdown && !ramp_en, "R1 reset controls", {slowdown, ramp_en}, 0);
    chk(step_a == 0 && step_b == 0, "R1 reset steps", {step_a, step_b}, 0);
    chk(ndiv == RST_N_VAL, "R1 reset divider", ndiv, RST_N_VAL);

    same_req();
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      run_ramp(NW'((int'(ndiv) + 1 + 37 * i) % 256), 3 * i, 1'b0, 1'b0);
      @(negedge clk);
    end

    run_ramp(8'd200, 30, 1'b0, 1'b1);
    @(negedge clk);

    run_ramp(8'd17, 0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(error == 1'b1, "R10 error held", error, 1);
    same_req();
    @(negedge clk);

    run_ramp(8'd99, 0, 1'b1, 1'b0);
    @(negedge clk);
    run_ramp(8'd150, 5, 1'b0, 1'b0);
    same_req();
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule